// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen peripherals, decides which one should be served first, and raises one interrupt output towards the processor. When the processor acknowledges, the block sends back a vector: a fixed base value plus the 4-bit number of the line that won. It uses two eight-line priority stages. The secondary stage handles global lines 8 to 15. Its combined request drives slot 2 of the primary stage, so that slot cannot carry a peripheral of its own.

Older software may still raise requests on line 2. Those requests, if enabled, are merged into line 9 and served as line 9. Each line latches its request on a rising edge and holds it as pending until it is acknowledged. An acknowledged line stays in service until an end-of-interrupt strobe names it. While a line is in service, requests of equal or lower priority are held back. A higher-priority request can still interrupt it. The vector output has no back-pressure. It is valid for exactly one cycle, and the processor must take it in that cycle. Requests, acknowledge and end-of-interrupt are plain control pins.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset `int_o` and `vec_valid` are low and no line is pending or in service.
- R2: A rising edge on a request line marks it pending. `int_o` rises on the cycle after the edge is sampled. A request held high at a constant level does not re-trigger once it has been serviced.
- R3: Priority from highest to lowest is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. The secondary lines share primary slot 2 as a group.
- R4: An enabled request on line 2 is served as line 9, with vector base+9. No vector ever carries line number 2.
- R5: A rising edge on `int_ack` while `int_o` is high selects the winning line. One cycle later `vec_valid` is high for exactly one cycle, and `vec_data` = `VEC_BASE` + line number. The line leaves pending and enters service.
- R6: A rising edge on `int_ack` while `int_o` is low produces no vector.
- R7: A line in service holds back `int_o` for lines of equal or lower priority. A pending line of higher priority raises `int_o` and can be acknowledged. This applies inside the secondary stage as well.
- R8: `eoi` with `eoi_line` clears that line's in-service state (`eoi_line` 2 means line 9). The secondary group's slot in the primary stage is released only when no secondary line remains in service.
- R9: A line whose bit in `irq_en` is low does not raise `int_o`, but its pending state is kept. Setting the bit later raises `int_o`. `irq_en[2]` gates the legacy line-2 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request lines; bit n is global line n |
| irq_en | input | 16 | Per-line enable mask |
| int_o | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge from the processor; acts on its rising edge |
| vec_valid | output | 1 | Vector valid for one cycle |
| vec_data | output | 8 | Vector: base plus line number |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 4 | Line whose service ends |

## Verification
Corrupt pending or in-service state shows up at the ports within a cycle or two. A lost pending bit never raises `int_o`. An in-service bit that sticks keeps `int_o` low for lower lines after their expected end-of-interrupt. A wrong priority order or a wrong rerouting shows up as a wrong `vec_data` on the cycle after the acknowledge. An early release of the primary slot 2 lets a lower primary line raise `int_o` while a secondary line is still in service.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
  localparam int STAGE_LINES  = 8;
  localparam int TOTAL_LINES  = 2 * STAGE_LINES;
  localparam int LINE_W       = $clog2(TOTAL_LINES);
  localparam int SLOT_W       = $clog2(STAGE_LINES);
  localparam int CASCADE_SLOT = 2;
  localparam int LEGACY_LINE  = 2;
  localparam int REMAP_LINE   = 9;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_stage.sv
module irq_stage #(
  parameter int N        = 8,
  parameter int CAS_SLOT = -1,
  parameter int IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  en,
  input  logic          grant,
  input  logic          eoi,
  input  logic [IW-1:0] eoi_idx,
  output logic          stage_int,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  isr_q
);
  logic [N-1:0] prev_q, pend_q, pend_eff, rise, blocked, eligible;

  assign rise = req & ~prev_q;

  // the cascade slot follows the lower stage's level instead of a latch
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (i == CAS_SLOT) pend_eff[i] = req[i] & en[i];
      else               pend_eff[i] = pend_q[i] & en[i];
    end
  end

  always_comb begin
    blocked = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j < i && isr_q[j]) blocked[i] = 1'b1;
      end
      if (i != CAS_SLOT && isr_q[i]) blocked[i] = 1'b1;
    end
  end

  assign eligible = pend_eff & ~blocked;

  irq_prio_pick #(.N(N), .IW(IW)) u_pick (
    .cand (eligible),
    .any  (stage_int),
    .idx  (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= req;
      for (int i = 0; i < N; i++) begin
        pend_q[i] <= rise[i] | (pend_q[i] & ~(grant && stage_int && win_idx == IW'(i)));
        isr_q[i]  <= (grant && stage_int && win_idx == IW'(i)) |
                     (isr_q[i] & ~(eoi && eoi_idx == IW'(i)));
      end
    end
  end

  // R5: an accepted grant leaves the winner in service
  a_r5_grant_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && stage_int && !eoi) |=> isr_q[$past(win_idx)]);

  // R2: a stage only requests with something pending and enabled
  a_r2_int_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    stage_int |-> (pend_eff != '0));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_casc_pkg::*;
#(
  parameter int            VEC_W    = 8,
  parameter logic [7:0]    VEC_BASE = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TOTAL_LINES-1:0] irq_req,
  input  logic [TOTAL_LINES-1:0] irq_en,
  output logic                   int_o,
  input  logic                   int_ack,
  output logic                   vec_valid,
  output logic [VEC_W-1:0]       vec_data,
  input  logic                   eoi,
  input  logic [LINE_W-1:0]      eoi_line
);
  localparam int SEC_REMAP = REMAP_LINE - STAGE_LINES;

  logic [STAGE_LINES-1:0] sec_req, sec_en, pri_req, pri_en, sec_isr, pri_isr;
  logic [STAGE_LINES-1:0] sec_left;
  logic                   sec_int, pri_int, ack_q, take;
  logic [SLOT_W-1:0]      sec_win, pri_win, sec_eoi_idx, pri_eoi_idx;
  logic [LINE_W-1:0]      line_sel, eoi_eff;
  logic                   sec_eoi, pri_eoi, pri_unused;

  // fold legacy line requests into the remapped secondary slot
  always_comb begin
    sec_req = irq_req[TOTAL_LINES-1:STAGE_LINES];
    sec_req[SEC_REMAP] = irq_req[REMAP_LINE] | (irq_req[LEGACY_LINE] & irq_en[LEGACY_LINE]);
    sec_en  = irq_en[TOTAL_LINES-1:STAGE_LINES];
    pri_req = irq_req[STAGE_LINES-1:0];
    pri_req[CASCADE_SLOT] = sec_int;
    pri_en  = irq_en[STAGE_LINES-1:0];
    pri_en[CASCADE_SLOT] = 1'b1;
  end

  assign take = int_ack & ~ack_q & pri_int;

  assign eoi_eff     = (eoi_line == LINE_W'(LEGACY_LINE)) ? LINE_W'(REMAP_LINE) : eoi_line;
  assign sec_eoi     = eoi & eoi_eff[LINE_W-1];
  assign sec_eoi_idx = eoi_eff[SLOT_W-1:0];
  assign sec_left    = sec_isr & ~(STAGE_LINES'(1) << sec_eoi_idx);
  assign pri_eoi     = eoi & (~eoi_eff[LINE_W-1] | (sec_left == '0));
  assign pri_eoi_idx = eoi_eff[LINE_W-1] ? SLOT_W'(CASCADE_SLOT) : eoi_eff[SLOT_W-1:0];
  assign pri_unused  = ^pri_isr;

  irq_stage #(.N(STAGE_LINES), .CAS_SLOT(-1)) u_sec (
    .clk(clk), .rst_n(rst_n), .req(sec_req), .en(sec_en),
    .grant(take && pri_win == SLOT_W'(CASCADE_SLOT)),
    .eoi(sec_eoi), .eoi_idx(sec_eoi_idx),
    .stage_int(sec_int), .win_idx(sec_win), .isr_q(sec_isr)
  );

  irq_stage #(.N(STAGE_LINES), .CAS_SLOT(CASCADE_SLOT)) u_pri (
    .clk(clk), .rst_n(rst_n), .req(pri_req), .en(pri_en),
    .grant(take), .eoi(pri_eoi), .eoi_idx(pri_eoi_idx),
    .stage_int(pri_int), .win_idx(pri_win), .isr_q(pri_isr)
  );

  assign int_o = pri_int;

  assign line_sel = (pri_win == SLOT_W'(CASCADE_SLOT)) ? {1'b1, sec_win} : {1'b0, pri_win};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      ack_q     <= int_ack;
      vec_valid <= take;
      if (take) vec_data <= VEC_W'(VEC_BASE) + VEC_W'(line_sel);
    end
  end

  // R5: vector lasts a single cycle
  a_r5_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  // R6: a vector only follows an acknowledge with the interrupt raised
  a_r6_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(int_ack) && $past(int_o)));
  // R4: line 2 never appears in a vector
  a_r4_no_legacy_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data != VEC_W'(VEC_BASE) + VEC_W'(LEGACY_LINE)));
  // R8: the primary cascade slot stays in service while any secondary line is
  a_r8_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_isr != '0) |-> (pri_isr[CASCADE_SLOT] || pri_unused || !pri_unused) && pri_isr[CASCADE_SLOT]);
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic [15:0] irq_en = '1;
  logic        int_ack = 1'b0;
  logic        eoi = 1'b0;
  logic [3:0]  eoi_line = '0;
  logic        int_o, vec_valid;
  logic [7:0]  vec_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .int_o(int_o), .int_ack(int_ack), .vec_valid(vec_valid),
    .vec_data(vec_data), .eoi(eoi), .eoi_line(eoi_line)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic ack_expect(string tag, int line);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk({tag, " vec_valid"}, vec_valid, 1);
    chk({tag, " vec_data"}, vec_data, 8'h20 + line);
    @(negedge clk);
    chk({tag, " vec one cycle"}, vec_valid, 0);
  endtask

  task automatic end_irq(int line);
    eoi = 1'b1;
    eoi_line = 4'(line);
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 int_o", int_o, 0);
    chk("R1 vec_valid", vec_valid, 0);
  endtask

  task automatic t_single;
    pulse(16'h0020);
    chk("R2 int after edge", int_o, 1);
    ack_expect("R5 line5", 5);
    chk("R5 int drops after ack", int_o, 0);
    end_irq(5);
    chk("R5 no re-request", int_o, 0);
  endtask

  task automatic t_priority;
    pulse(16'h1012);
    ack_expect("R3 first", 1);
    chk("R7 blocked by line1", int_o, 0);
    end_irq(1);
    chk("R3 int after eoi", int_o, 1);
    ack_expect("R3 second", 12);
    chk("R7 line4 held by group", int_o, 0);
    end_irq(12);
    ack_expect("R3 third", 4);
    end_irq(4);
  endtask

  task automatic t_legacy;
    pulse(16'h0004);
    chk("R4 int", int_o, 1);
    ack_expect("R4 remapped", 9);
    end_irq(2);
    chk("R8 eoi line2 clears 9", int_o, 0);
    pulse(16'h0040);
    ack_expect("R8 line6 after eoi2", 6);
    end_irq(6);
  endtask

  task automatic t_spurious_ack;
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk("R6 no vector", vec_valid, 0);
    @(negedge clk);
    chk("R6 still none", vec_valid, 0);
  endtask

  task automatic t_nesting;
    pulse(16'h0040);
    ack_expect("R7 line6", 6);
    pulse(16'h0080);
    chk("R7 lower held", int_o, 0);
    pulse(16'h0008);
    chk("R7 higher passes", int_o, 1);
    ack_expect("R7 line3", 3);
    end_irq(3);
    chk("R7 line7 still held", int_o, 0);
    end_irq(6);
    chk("R8 line7 released", int_o, 1);
    ack_expect("R8 line7", 7);
    end_irq(7);
    pulse(16'h2000);
    ack_expect("R7 line13", 13);
    pulse(16'h0400);
    chk("R7 secondary higher", int_o, 1);
    ack_expect("R7 line10", 10);
    end_irq(10);
    pulse(16'h0010);
    chk("R8 slot still held", int_o, 0);
    end_irq(13);
    chk("R8 slot released", int_o, 1);
    ack_expect("R8 line4", 4);
    end_irq(4);
  endtask

  task automatic t_mask;
    irq_en = 16'hF7FF;
    pulse(16'h0800);
    chk("R9 masked", int_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 still masked", int_o, 0);
    irq_en = '1;
    @(negedge clk);
    chk("R9 kept pending", int_o, 1);
    ack_expect("R9 line11", 11);
    end_irq(11);
    irq_en = 16'hFFFB;
    pulse(16'h0004);
    chk("R9 legacy gated", int_o, 0);
    irq_en = '1;
    @(negedge clk);
    chk("R9 legacy dropped", int_o, 0);
  endtask

  task automatic t_level;
    irq_req = 16'h0020;
    @(negedge clk);
    ack_expect("R2 level", 5);
    end_irq(5);
    repeat (2) @(negedge clk);
    chk("R2 level no retrigger", int_o, 0);
    irq_req = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_legacy();
    t_spurious_ack();
    t_nesting();
    t_mask();
    t_level();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule